// File: doc/BRIEF.md
# Path RDI Insertion Controller

This block forms the outgoing path status byte (G1) of a SONET transmitter. The byte carries a remote error field in its upper nibble, a three-bit remote defect indication (RDI) field in bits 3:1, and a zero in bit 0. The RDI field comes from one of two sources. In the defect-driven mode, each of two receive-side defects has its own programmed three-bit code and its own enable: loss of cell delineation (LCD) and payload label mismatch (PLM). In the firmware mode, the field is copied from a byte that software has written.

Three byte-wide registers set up the block through a simple write port with a combinational read port. The defect codes and enables share one configuration byte. An insertion-type field in a path control byte selects the mode. A third byte holds the firmware G1 value. The assembled byte is captured once per frame, on a one-cycle strobe that marks the G1 byte time, so the output never changes between two strobes.

Top module: `path_rdi_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00 and `g1_out` is 0x00, so the defect-driven mode is active with both defect enables cleared.
- R2: The defect configuration register at address 0x49 stores and reads back all eight bits. Its fields are: bits 7:5 the LCD code, bit 4 the LCD enable, bits 3:1 the PLM code, bit 0 the PLM enable. The firmware G1 register at address 0x06 stores and reads back all eight bits. Unmapped addresses read 0x00.
- R3: The path control register is at address 0x03, and its insertion type is in bits 4:3. Its bit 1 always reads 0, whatever was written to it. Its other seven bits read back as written.
- R4: In the defect-driven mode, while `lcd_dfct` is 1 and the LCD enable is 1, the captured RDI field equals the LCD code.
- R5: In the defect-driven mode, while `plm_dfct` is 1, the PLM enable is 1, and no enabled LCD is present, the captured RDI field equals the PLM code.
- R6: When both defects are declared and both are enabled, the LCD code wins.
- R7: In the defect-driven mode, the RDI field is 000 when no declared defect has its enable set. A declared defect whose enable is 0 has no effect.
- R8: An insertion type of 01 selects the firmware mode. In that mode the RDI field is bits 3:1 of the firmware G1 register, and both defect inputs are ignored.
- R9: Insertion types 00, 10 and 11 all select the defect-driven mode.
- R10: `g1_out` changes only on a clock edge where `g1_tick` is 1. At every other edge it holds its value.
- R11: On a `g1_tick` edge, `g1_out[7:4]` takes `rei_val` and `g1_out[0]` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| lcd_dfct | input | 1 | LCD defect declared by the receive side |
| plm_dfct | input | 1 | PLM defect declared by the receive side |
| rei_val | input | 4 | Remote error value for G1 bits 7:4 |
| g1_tick | input | 1 | One-cycle G1 byte-time strobe |
| g1_out | output | 8 | Assembled G1 byte |

## Verification
The assertions assume that the defect flags, the remote error value and the register contents are stable and known at every clock edge after reset. They also assume that the G1 strobe is a clean single-cycle pulse. The bench drives every input on the falling clock edge and raises the strobe for exactly one cycle. It writes registers only while the strobe is low, so each captured byte reflects one settled configuration. The defect flags are also toggled between strobes, which shows that the output waits for the next G1 byte time.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
  localparam int BYTE_W   = 8;
  localparam int RDI_W    = 3;
  localparam int REI_W    = 4;
  localparam int NUM_DFCT = 2;
  localparam int NIB_W    = RDI_W + 1;

  typedef enum logic [1:0] {
    INS_DEFECT   = 2'b00,
    INS_FIRMWARE = 2'b01,
    INS_RSVD_A   = 2'b10,
    INS_RSVD_B   = 2'b11
  } ins_type_e;

  typedef struct packed {
    logic [RDI_W-1:0] code;
    logic             en;
  } dfct_cfg_t;
endpackage

// File: rtl/rdi_reg_bank.sv
module rdi_reg_bank
  import rdi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h49,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h03,
  parameter logic [ADDR_W-1:0] SWG1_ADDR = 8'h06,
  parameter logic [BYTE_W-1:0] CTL_RO_MASK = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [BYTE_W-1:0] swg1_q
);
  logic              cfg_we, ctl_we, swg1_we;
  logic [BYTE_W-1:0] cfg_d, ctl_d, swg1_d;

  always_comb begin
    cfg_we  = wr_en && (addr == CFG_ADDR);
    ctl_we  = wr_en && (addr == CTL_ADDR);
    swg1_we = wr_en && (addr == SWG1_ADDR);
    cfg_d   = wdata;
    ctl_d   = wdata & ~CTL_RO_MASK;
    swg1_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swg1_q <= '0;
    end else if (swg1_we) begin
      swg1_q <= swg1_d;
    end
  end

  always_comb begin
    unique case (1'b1)
      (addr == CFG_ADDR):  rdata = cfg_q;
      (addr == CTL_ADDR):  rdata = ctl_q;
      (addr == SWG1_ADDR): rdata = swg1_q;
      default:             rdata = '0;
    endcase
  end

  // R2
  cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CFG_ADDR) |=> (cfg_q == $past(wdata)));

  // R3
  ctl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTL_ADDR) |=> (ctl_q == ($past(wdata) & ~CTL_RO_MASK)));
endmodule

// File: rtl/rdi_code_mux.sv
module rdi_code_mux
  import rdi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTE_W-1:0]   cfg,
  input  ins_type_e           ins_type,
  input  logic [BYTE_W-1:0]   swg1,
  input  logic [NUM_DFCT-1:0] dfct,
  output logic [RDI_W-1:0]    rdi_sel
);
  dfct_cfg_t           dcfg [NUM_DFCT];
  logic [NUM_DFCT-1:0] hit;
  logic [RDI_W-1:0]    auto_code;
  logic                fw_mode;

  // Index 0 sits in the top nibble and has the highest priority.
  for (genvar gi = 0; gi < NUM_DFCT; gi++) begin : g_dfct
    assign dcfg[gi] = cfg[BYTE_W-1-gi*NIB_W -: NIB_W];
    assign hit[gi]  = dfct[gi] & dcfg[gi].en;
  end

  always_comb begin
    auto_code = '0;
    for (int i = NUM_DFCT - 1; i >= 0; i--) begin
      if (hit[i]) auto_code = dcfg[i].code;
    end
  end

  always_comb begin
    fw_mode = (ins_type == INS_FIRMWARE);
    rdi_sel = fw_mode ? swg1[RDI_W:1] : auto_code;
  end

  // R6
  lcd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_type != INS_FIRMWARE && dfct[0] && cfg[4]) |-> (rdi_sel == cfg[7:5]));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_type != INS_FIRMWARE && !(dfct[0] && cfg[4]) && !(dfct[1] && cfg[0]))
      |-> (rdi_sel == '0));

  // R8
  fw_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_type == INS_FIRMWARE) |-> (rdi_sel == swg1[3:1]));
endmodule

// File: rtl/g1_out_stage.sv
module g1_out_stage
  import rdi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [REI_W-1:0]  rei,
  input  logic [RDI_W-1:0]  rdi,
  output logic [BYTE_W-1:0] g1_q
);
  logic [BYTE_W-1:0] g1_d;

  always_comb begin
    g1_d = {rei, rdi, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= '0;
    end else if (tick) begin
      g1_q <= g1_d;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(g1_q));

  // R11
  rei_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (g1_q[7:4] == $past(rei) && g1_q[0] == 1'b0));

  // R10
  rdi_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (g1_q[3:1] == $past(rdi)));
endmodule

// File: rtl/path_rdi_ctrl.sv
module path_rdi_ctrl
  import rdi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h49,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h03,
  parameter logic [ADDR_W-1:0] SWG1_ADDR = 8'h06,
  parameter int INS_LSB = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              lcd_dfct,
  input  logic              plm_dfct,
  input  logic [3:0]        rei_val,
  input  logic              g1_tick,
  output logic [7:0]        g1_out
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [BYTE_W-1:0]      cfg_q, ctl_q, swg1_q;
  logic [RDI_W-1:0]       rdi_sel;
  ins_type_e              ins_type;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  rdi_reg_bank #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR), .SWG1_ADDR(SWG1_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg_q(cfg_q), .ctl_q(ctl_q), .swg1_q(swg1_q)
  );

  assign ins_type = ins_type_e'(ctl_q[INS_LSB +: 2]);

  rdi_code_mux u_mux (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg_q), .ins_type(ins_type),
    .swg1(swg1_q), .dfct({plm_dfct, lcd_dfct}), .rdi_sel(rdi_sel)
  );

  g1_out_stage u_out (
    .clk(clk), .rst_n(rst_int_n), .tick(g1_tick), .rei(rei_val),
    .rdi(rdi_sel), .g1_q(g1_out)
  );

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (g1_out == '0 && cfg_q == '0 && ctl_q == '0 && swg1_q == '0));
endmodule

// File: tb/test_path_rdi_ctrl.sv
module test_path_rdi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       lcd_dfct, plm_dfct;
  logic [3:0] rei_val;
  logic       g1_tick;
  logic [7:0] g1_out;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [7:0] A_CFG = 8'h49, A_CTL = 8'h03, A_SW = 8'h06;

  // {req[3:0], cfg, ctl, sw, lcd, plm, rei[3:0], expected g1}
  localparam int NV = 11;
  localparam logic [41:0] VEC [NV] = '{
    {4'd4,  8'hB0, 8'h00, 8'h00, 1'b1, 1'b0, 4'h3, 8'h3A},
    {4'd5,  8'h07, 8'h00, 8'h00, 1'b0, 1'b1, 4'hA, 8'hA6},
    {4'd6,  8'hD3, 8'h00, 8'h00, 1'b1, 1'b1, 4'h5, 8'h5C},
    {4'd5,  8'hD3, 8'h00, 8'h00, 1'b0, 1'b1, 4'h0, 8'h02},
    {4'd7,  8'hD3, 8'h00, 8'h00, 1'b0, 1'b0, 4'hF, 8'hF0},
    {4'd7,  8'hC2, 8'h00, 8'h00, 1'b1, 1'b1, 4'h1, 8'h10},
    {4'd8,  8'hD3, 8'h08, 8'h0E, 1'b1, 1'b1, 4'h2, 8'h2E},
    {4'd8,  8'hD3, 8'h08, 8'hF5, 1'b0, 1'b0, 4'h6, 8'h64},
    {4'd9,  8'hD3, 8'h10, 8'h0E, 1'b1, 1'b0, 4'h7, 8'h7C},
    {4'd9,  8'hD3, 8'h18, 8'h0E, 1'b0, 1'b1, 4'h8, 8'h82},
    {4'd9,  8'hD3, 8'hE7, 8'h0E, 1'b0, 1'b1, 4'h9, 8'h92}
  };

  path_rdi_ctrl i_path_rdi_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcd_dfct(lcd_dfct),
    .plm_dfct(plm_dfct), .rei_val(rei_val), .g1_tick(g1_tick), .g1_out(g1_out)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    g1_tick = 1'b1;
    @(negedge clk);
    g1_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    lcd_dfct = 1'b0; plm_dfct = 1'b0; rei_val = '0; g1_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 g1_out", g1_out, 8'h00);
    rd_chk("R1 cfg", A_CFG, 8'h00);
    rd_chk("R1 ctl", A_CTL, 8'h00);
    rd_chk("R1 sw", A_SW, 8'h00);
    lcd_dfct = 1'b1; plm_dfct = 1'b1; rei_val = 4'h0;
    pulse_tick();
    check("R1 enables off after reset", g1_out, 8'h00);

    // Vector table walk (R4 R5 R6 R7 R8 R9 R11)
    for (int v = 0; v < NV; v++) begin
      wr_reg(A_CFG, VEC[v][37:30]);
      wr_reg(A_CTL, VEC[v][29:22]);
      wr_reg(A_SW,  VEC[v][21:14]);
      @(negedge clk);
      lcd_dfct = VEC[v][13]; plm_dfct = VEC[v][12]; rei_val = VEC[v][11:8];
      pulse_tick();
      check($sformatf("R%0d vector %0d", VEC[v][41:38], v), g1_out, VEC[v][7:0]);
    end

    // R2 read back
    wr_reg(A_CFG, 8'hA5);
    rd_chk("R2 cfg readback", A_CFG, 8'hA5);
    wr_reg(A_SW, 8'h5A);
    rd_chk("R2 sw readback", A_SW, 8'h5A);
    rd_chk("R2 unmapped", 8'h77, 8'h00);

    // R3 bit 1 of control reads zero
    wr_reg(A_CTL, 8'hFF);
    rd_chk("R3 ctl bit1", A_CTL, 8'hFD);
    wr_reg(A_CTL, 8'h02);
    rd_chk("R3 ctl only bit1", A_CTL, 8'h00);

    // R10 hold between ticks: cfg 0xA5 = LCD code 101 en 0, PLM code 010 en 1
    @(negedge clk);
    lcd_dfct = 1'b0; plm_dfct = 1'b1; rei_val = 4'hC;
    pulse_tick();
    check("R10 captured", g1_out, 8'hC4);
    @(negedge clk);
    plm_dfct = 1'b0; rei_val = 4'h3;
    repeat (4) @(negedge clk);
    check("R10 hold without tick", g1_out, 8'hC4);
    wr_reg(A_CFG, 8'hF0);
    lcd_dfct = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 hold after reconfig", g1_out, 8'hC4);
    pulse_tick();
    check("R4 after tick", g1_out, 8'h3E);

    // R8 firmware mode ignores defects
    wr_reg(A_CTL, 8'h08);
    wr_reg(A_SW, 8'h00);
    @(negedge clk);
    lcd_dfct = 1'b1; plm_dfct = 1'b1; rei_val = 4'h0;
    pulse_tick();
    check("R8 defects ignored", g1_out, 8'h00);

    // R11 bit 0 stays zero even if firmware byte has bit 0 set
    wr_reg(A_SW, 8'hFF);
    @(negedge clk);
    rei_val = 4'hF;
    pulse_tick();
    check("R11 bit0 zero", g1_out, 8'hFE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule